// File: doc/BRIEF.md
# Flash Write Command Sequence Decoder

This block watches the write side of an asynchronous flash-style bus (active-low chip select, active-low write enable, address and byte data) and picks out the multi-write command sequences that start an embedded operation. It runs on a free-running system clock. It passes both strobes through a short synchronizer and treats each stretch in which both strobes are low as one bus write.

Two sequences are recognized. The first is a four-write byte program. The second is a six-write erase, which repeats the unlock pair before the final command and then selects either the whole array or one sector. When a sequence completes, the decoder emits a single-clock start pulse for that operation. The address and data of the final write appear on the command outputs at the same time. Any write that breaks a sequence returns the decoder to read mode. While the downstream engine reports busy, writes are not decoded.

The array, the program and erase engines, erase timers and status reporting sit outside this block and consume its pulses.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, no start pulse is active, `cmdAddr` and `cmdData` are zero, and the decoder is in read mode.
- R2: The program sequence is four writes: data 0xAA at key address 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555, then any data at any address. This sequence gives exactly one `progStart` pulse, with `cmdAddr`/`cmdData` equal to the fourth write's address and data. The decoder is then back in read mode.
- R3: The address of a write is taken when the later of the two strobes falls, which is when both strobes become low. The data is taken when the first of them rises, which is when the pair stops being both low. Address or data changes outside those instants have no effect.
- R4: A start pulse rises on the (SYNC_STAGES+1)-th rising clock edge after the strobe edge that ends the final write.
- R5: The chip erase sequence is six writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x10@0x555. It gives one `chipEraseStart` pulse.
- R6: The sector erase sequence uses the same five leading writes as R5, then 0x30 at any address. It gives one `sectorEraseCmd` pulse, with `cmdAddr` carrying the full address of that write.
- R7: A write that does not match the next step expected by the current state ends the sequence and returns the decoder to read mode with no pulse. This holds even when the write is 0xAA@0x555 arriving mid-sequence.
- R8: Only address bits [10:0] are compared against key addresses, so the upper bits are free. A program may target any address, and sequences may follow one another with no gap.
- R9: A write that ends while `busy` is high produces no pulse and neither advances nor resets the sequence state.
- R10: The three start outputs are never high together, and each pulse lasts exactly one clock.
- R11: A strobe pulse while the other strobe stays high is not a write and leaves the sequence untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Bus chip select, active low, asynchronous |
| weN | input | 1 | Bus write enable, active low, asynchronous |
| addr | input | ADDR_W | Bus address |
| data | input | 8 | Bus write data |
| busy | input | 1 | Embedded operation in progress; writes are not decoded |
| progStart | output | 1 | One-clock byte program start |
| chipEraseStart | output | 1 | One-clock chip erase start |
| sectorEraseCmd | output | 1 | One-clock sector erase command |
| cmdAddr | output | ADDR_W | Address of the write that completed the sequence |
| cmdData | output | 8 | Data of the write that completed the sequence |

## Verification
A sequence state that is left stale or advances wrongly becomes visible at the ports only when the final write of a sequence ends. It shows either as a missing pulse, a pulse from an aborted sequence, or the wrong pulse type, always SYNC_STAGES+1 clocks after that write. Wrong capture instants show up as `cmdAddr`/`cmdData` holding values that were on the bus before or after the strobe overlap. The bench therefore moves address and data outside the overlap on purpose. It counts every pulse, checks its width and timing, and compares the captured values with the write that ended the sequence.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int KEY_ADDR_W = 11;
  localparam logic [KEY_ADDR_W-1:0] KEY_A_ADDR = 11'h555;
  localparam logic [KEY_ADDR_W-1:0] KEY_B_ADDR = 11'h2AA;

  localparam logic [7:0] KEY_A_DATA     = 8'hAA;
  localparam logic [7:0] KEY_B_DATA     = 8'h55;
  localparam logic [7:0] OP_PROG_SETUP  = 8'hA0;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h80;
  localparam logic [7:0] OP_CHIP_ERASE  = 8'h10;
  localparam logic [7:0] OP_SECT_ERASE  = 8'h30;

  typedef enum logic [2:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_PROG_DATA,
    ST_ERS_SETUP,
    ST_ERS_UNL1,
    ST_ERS_UNL2
  } cmdState_t;

  // Datapath -> control: one completed bus write and its decoded keys
  typedef struct packed {
    logic       wrEnd;
    logic       atKeyA;
    logic       atKeyB;
    logic [7:0] wrData;
  } cycInfo_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic latchCmd;
  } dpStrobe_t;

endpackage

// File: rtl/flash_cmd_sync.sv
module flash_cmd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[0] <= RST_VAL;
        else       pipe[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[i] <= RST_VAL;
        else       pipe[i] <= pipe[i-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/flash_cmd_dpath.sv
module flash_cmd_dpath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  dpStrobe_t         strobe,
  output cycInfo_t          cyc,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [7:0]        cmdData
);

  logic csS, weS;
  logic act, actPrev;
  logic wrBegin, wrEnd;
  logic [ADDR_W-1:0] addrLat;

  flash_cmd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_csSync (
    .clk(clk), .rstN(rstN), .din(csN), .dout(csS)
  );
  flash_cmd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_weSync (
    .clk(clk), .rstN(rstN), .din(weN), .dout(weS)
  );

  // A bus write is the overlap of both strobes low
  assign act     = !csS && !weS;
  assign wrBegin = act && !actPrev;   // later falling edge
  assign wrEnd   = !act && actPrev;   // first rising edge

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPrev <= 1'b0;
      addrLat <= '0;
    end else begin
      actPrev <= act;
      if (wrBegin) addrLat <= addr;
    end
  end

  always_comb begin
    cyc.wrEnd  = wrEnd;
    cyc.atKeyA = (addrLat[KEY_ADDR_W-1:0] == KEY_A_ADDR);
    cyc.atKeyB = (addrLat[KEY_ADDR_W-1:0] == KEY_B_ADDR);
    cyc.wrData = data;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdAddr <= '0;
      cmdData <= '0;
    end else if (strobe.latchCmd) begin
      cmdAddr <= addrLat;
      cmdData <= data;
    end
  end

  AST_ADDR_HELD_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (act && actPrev) |=> $stable(addrLat)); // R3
  AST_LATCH_AT_WRITE_END: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchCmd |-> wrEnd); // R3
  AST_CMD_HELD_WITHOUT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchCmd |=> ($stable(cmdAddr) && $stable(cmdData))); // R2

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busy,
  input  cycInfo_t  cyc,
  output dpStrobe_t strobe,
  output logic      progStart,
  output logic      chipEraseStart,
  output logic      sectorEraseCmd
);

  cmdState_t state, nextState;
  logic accept, keyA, keyB;
  logic goProg, goChip, goSector;

  assign accept = cyc.wrEnd && !busy;
  assign keyA   = cyc.atKeyA && (cyc.wrData == KEY_A_DATA);
  assign keyB   = cyc.atKeyB && (cyc.wrData == KEY_B_DATA);

  always_comb begin
    nextState = state;
    goProg    = 1'b0;
    goChip    = 1'b0;
    goSector  = 1'b0;
    if (accept) begin
      nextState = ST_READ;
      case (state)
        ST_READ:      if (keyA) nextState = ST_UNL1;
        ST_UNL1:      if (keyB) nextState = ST_UNL2;
        ST_UNL2: begin
          if (cyc.atKeyA && cyc.wrData == OP_PROG_SETUP)       nextState = ST_PROG_DATA;
          else if (cyc.atKeyA && cyc.wrData == OP_ERASE_SETUP) nextState = ST_ERS_SETUP;
        end
        ST_PROG_DATA: goProg = 1'b1;
        ST_ERS_SETUP: if (keyA) nextState = ST_ERS_UNL1;
        ST_ERS_UNL1:  if (keyB) nextState = ST_ERS_UNL2;
        ST_ERS_UNL2: begin
          if (cyc.atKeyA && cyc.wrData == OP_CHIP_ERASE) goChip = 1'b1;
          else if (cyc.wrData == OP_SECT_ERASE)          goSector = 1'b1;
        end
        default:      nextState = ST_READ;
      endcase
    end
  end

  assign strobe.latchCmd = goProg || goChip || goSector;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_READ;
      progStart      <= 1'b0;
      chipEraseStart <= 1'b0;
      sectorEraseCmd <= 1'b0;
    end else begin
      state          <= nextState;
      progStart      <= goProg;
      chipEraseStart <= goChip;
      sectorEraseCmd <= goSector;
    end
  end

  AST_STARTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progStart, chipEraseStart, sectorEraseCmd})); // R10
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (progStart || chipEraseStart || sectorEraseCmd)
      |=> !(progStart || chipEraseStart || sectorEraseCmd)); // R10
  AST_READ_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    (progStart || chipEraseStart || sectorEraseCmd) |-> (state == ST_READ)); // R2
  AST_START_FROM_WRITE_END: assert property (@(posedge clk) disable iff (!rstN)
    (progStart || chipEraseStart || sectorEraseCmd) |-> $past(cyc.wrEnd)); // R4
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (cyc.wrEnd && busy) |=> !(progStart || chipEraseStart || sectorEraseCmd)); // R9
  AST_BUSY_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(state)); // R9

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              busy,
  output logic              progStart,
  output logic              chipEraseStart,
  output logic              sectorEraseCmd,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [7:0]        cmdData
);

  cycInfo_t  cyc;
  dpStrobe_t strobe;

  flash_cmd_dpath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .addr(addr), .data(data),
    .strobe(strobe), .cyc(cyc), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  flash_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busy(busy), .cyc(cyc), .strobe(strobe),
    .progStart(progStart), .chipEraseStart(chipEraseStart),
    .sectorEraseCmd(sectorEraseCmd)
  );

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  localparam int ADDR_W   = 19;
  localparam int SYNC     = 2;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, weN = 1'b1, busy = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] data = '0;
  logic progStart, chipEraseStart, sectorEraseCmd;
  logic [ADDR_W-1:0] cmdAddr;
  logic [7:0] cmdData;

  always #4 clk = ~clk;   // 125 MHz

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .addr(addr), .data(data),
    .busy(busy), .progStart(progStart), .chipEraseStart(chipEraseStart),
    .sectorEraseCmd(sectorEraseCmd), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  int checks = 0, fails = 0;
  int cycCnt = 0, relCyc = 0;
  int progCnt = 0, chipCnt = 0, sectCnt = 0, widthErr = 0;
  int lastCyc = 0;
  logic [ADDR_W-1:0] lastAddr = '0;
  logic [7:0] lastData = '0;
  logic prevAny = 1'b0;

  always @(posedge clk) begin
    cycCnt <= cycCnt + 1;
    if (cycCnt == WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cycCnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // Pulse monitor, away from the active edge
  always @(negedge clk) begin
    if (($countones({progStart, chipEraseStart, sectorEraseCmd}) > 1) ||
        (prevAny && (progStart || chipEraseStart || sectorEraseCmd)))
      widthErr++;
    prevAny = progStart || chipEraseStart || sectorEraseCmd;
    if (progStart || chipEraseStart || sectorEraseCmd) begin
      lastCyc  = cycCnt;
      lastAddr = cmdAddr;
      lastData = cmdData;
    end
    if (progStart)      progCnt++;
    if (chipEraseStart) chipCnt++;
    if (sectorEraseCmd) sectCnt++;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; data = d; csN = 1'b0;
    @(negedge clk); weN = 1'b0;
    repeat (4) @(negedge clk);
    weN = 1'b1; relCyc = cycCnt;
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Write with bus values moving outside the capture instants
  task automatic skewWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                           input bit weFirst);
    @(negedge clk); addr = 19'h1_1111; data = 8'hEE;
    if (weFirst) weN = 1'b0; else csN = 1'b0;
    repeat (3) @(negedge clk);
    addr = a;
    @(negedge clk);
    if (weFirst) csN = 1'b0; else weN = 1'b0;
    repeat (4) @(negedge clk);
    addr = 19'h2_2222; data = d;
    @(negedge clk);
    if (weFirst) csN = 1'b1; else weN = 1'b1;
    relCyc = cycCnt;
    repeat (4) @(negedge clk);
    data = 8'h99;
    repeat (3) @(negedge clk);
    csN = 1'b1; weN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic unlockPair();
    busWrite(19'h00555, 8'hAA);
    busWrite(19'h002AA, 8'h55);
  endtask

  task automatic t_reset();
    check(!progStart && !chipEraseStart && !sectorEraseCmd, "R1 pulses idle", 
          {progStart, chipEraseStart, sectorEraseCmd}, 0);
    check(cmdAddr == 0 && cmdData == 0, "R1 cmd outputs zero", {cmdAddr, cmdData}, 0);
  endtask

  task automatic t_program();
    int p0 = progCnt;
    unlockPair();
    busWrite(19'h00555, 8'hA0);
    busWrite(19'h4_1234, 8'h5A);
    check(progCnt == p0 + 1, "R2 one program pulse", progCnt - p0, 1);
    check(lastAddr == 19'h4_1234, "R2 program address", lastAddr, 19'h4_1234);
    check(lastData == 8'h5A, "R2 program data", lastData, 8'h5A);
    check(lastCyc - relCyc == SYNC + 1, "R4 start latency", lastCyc - relCyc, SYNC + 1);
  endtask

  task automatic t_skewProgram();
    int p0 = progCnt;
    unlockPair();
    busWrite(19'h00555, 8'hA0);
    skewWrite(19'h3_0F0F, 8'hC3, 1'b0);
    check(progCnt == p0 + 1, "R3 program with skewed strobes", progCnt - p0, 1);
    check(lastAddr == 19'h3_0F0F, "R3 address at later falling edge", lastAddr, 19'h3_0F0F);
    check(lastData == 8'hC3, "R3 data at first rising edge", lastData, 8'hC3);
    check(lastCyc - relCyc == SYNC + 1, "R4 latency on skewed write", lastCyc - relCyc, SYNC + 1);
  endtask

  task automatic t_chipErase();
    int c0 = chipCnt, p0 = progCnt, s0 = sectCnt;
    unlockPair();
    busWrite(19'h00555, 8'h80);
    unlockPair();
    busWrite(19'h00555, 8'h10);
    check(chipCnt == c0 + 1, "R5 one chip erase pulse", chipCnt - c0, 1);
    check(progCnt == p0 && sectCnt == s0, "R5 no other pulse",
          (progCnt - p0) + (sectCnt - s0), 0);
    check(lastData == 8'h10, "R5 chip erase data", lastData, 8'h10);
  endtask

  task automatic t_sectorErase();
    int s0 = sectCnt, c0 = chipCnt;
    unlockPair();
    busWrite(19'h00555, 8'h80);
    unlockPair();
    skewWrite(19'h7_0123, 8'h30, 1'b1);
    check(sectCnt == s0 + 1, "R6 one sector erase pulse", sectCnt - s0, 1);
    check(chipCnt == c0, "R6 no chip erase", chipCnt - c0, 0);
    check(lastAddr == 19'h7_0123, "R6 sector address (R3 WE first)", lastAddr, 19'h7_0123);
  endtask

  task automatic t_abort();
    int p0 = progCnt, c0 = chipCnt, s0 = sectCnt;
    // repeated key A mid-sequence aborts; the rest is not a full sequence
    busWrite(19'h00555, 8'hAA);
    busWrite(19'h00555, 8'hAA);
    busWrite(19'h002AA, 8'h55);
    busWrite(19'h00555, 8'hA0);
    busWrite(19'h0_0042, 8'h11);
    check(progCnt == p0, "R7 repeated key A aborts", progCnt - p0, 0);
    // wrong command after unlocks
    unlockPair();
    busWrite(19'h00555, 8'h90);
    busWrite(19'h0_0043, 8'h22);
    check(progCnt == p0, "R7 unknown setup aborts", progCnt - p0, 0);
    // erase broken in second unlock pair
    unlockPair();
    busWrite(19'h00555, 8'h80);
    busWrite(19'h00555, 8'hAA);
    busWrite(19'h00123, 8'h55);
    busWrite(19'h00555, 8'h10);
    busWrite(19'h00555, 8'h30);
    check(chipCnt == c0 && sectCnt == s0, "R7 broken erase gives no pulse",
          (chipCnt - c0) + (sectCnt - s0), 0);
    // decoder is back in read mode: a clean program works
    unlockPair();
    busWrite(19'h00555, 8'hA0);
    busWrite(19'h0_0044, 8'h33);
    check(progCnt == p0 + 1, "R7 read mode after abort", progCnt - p0, 1);
  endtask

  task automatic t_anyAddr();
    int p0 = progCnt;
    busWrite(19'h7_D555, 8'hAA);
    busWrite(19'h2_02AA, 8'h55);
    busWrite(19'h1_0555, 8'hA0);
    busWrite(19'h7_FFFF, 8'h00);
    check(progCnt == p0 + 1 && lastAddr == 19'h7_FFFF, "R8 high key bits ignored, top address",
          lastAddr, 19'h7_FFFF);
    unlockPair();
    busWrite(19'h00555, 8'hA0);
    busWrite(19'h0_0000, 8'hFF);
    check(progCnt == p0 + 2, "R8 back-to-back programs", progCnt - p0, 2);
    check(lastAddr == 0 && lastData == 8'hFF, "R8 second program values",
          {lastAddr, lastData}, {19'h0, 8'hFF});
  endtask

  task automatic t_busy();
    int p0 = progCnt;
    unlockPair();
    @(negedge clk); busy = 1'b1;
    busWrite(19'h00777, 8'h12);
    @(negedge clk); busy = 1'b0;
    busWrite(19'h00555, 8'hA0);
    busWrite(19'h0_5555, 8'h66);
    check(progCnt == p0 + 1, "R9 write under busy keeps sequence", progCnt - p0, 1);
    @(negedge clk); busy = 1'b1;
    unlockPair();
    busWrite(19'h00555, 8'hA0);
    busWrite(19'h0_1111, 8'h77);
    @(negedge clk); busy = 1'b0;
    check(progCnt == p0 + 1, "R9 full sequence under busy ignored", progCnt - p0, 1);
    check(lastData == 8'h66, "R9 cmd outputs unchanged under busy", cmdData, 8'h66);
  endtask

  task automatic t_halfStrobe();
    int p0 = progCnt;
    busWrite(19'h00555, 8'hAA);
    @(negedge clk); addr = 19'h00123; data = 8'h77; weN = 1'b0;
    repeat (5) @(negedge clk); weN = 1'b1;
    repeat (3) @(negedge clk); csN = 1'b0;
    repeat (5) @(negedge clk); csN = 1'b1;
    repeat (3) @(negedge clk);
    busWrite(19'h002AA, 8'h55);
    busWrite(19'h00555, 8'hA0);
    busWrite(19'h0_0ABC, 8'h44);
    check(progCnt == p0 + 1, "R11 single strobe is not a write", progCnt - p0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_program();
    t_skewProgram();
    t_chipErase();
    t_sectorErase();
    t_abort();
    t_anyAddr();
    t_busy();
    t_halfStrobe();
    repeat (4) @(negedge clk);
    check(widthErr == 0, "R10 pulses one clock and exclusive", widthErr, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule